// File: doc/BRIEF.md
# Asynchronous External Bus Cycle Generator

This block sits between an internal single-beat request port and an external SRAM-style bus with six device regions. Each internal request carries a 32-bit word address, a read or write flag and, for writes, a 32-bit word. The top bits of the address pick one of the regions. The block then drives a timed external cycle on that region's select line: address and select first, the read or write strobe after a programmable lead-in, the strobe held for a programmable count or until the device acknowledges, and the select kept active for a programmable tail after the strobe.

Every region has its own static settings, applied on input pins. They set a 16- or 32-bit device width, byte order, whether the device acknowledge ends the strobe, write protection, and the three 4-bit cycle counts. A 32-bit access to a 16-bit device becomes two external beats. The block answers each request with a one-cycle response that carries read data and an error flag. The error flag is raised for an undecoded region, for a write to a protected region, and for an acknowledge that never arrives.

Top module: `async_bus_engine`

## Requirements
- R1: After reset all select lines, both strobes and the write-data enable are inactive (selects and strobes high, enable low), `req_ready` is high and `rsp_valid` is low.
- R2: The select index is `req_addr[ADDR_W-1 -: 3]`. During a cycle only the select line of that index is low. Index 6 or 7 returns an error response with no select asserted.
- R3: After acceptance, the select is asserted and the strobe stays high for exactly `setup` cycles before it goes low. This holds for each beat.
- R4: With acknowledge disabled, the strobe stays low for `wait+1` cycles. `bus_oe_n` is the strobe for reads and `bus_we_n` for writes, and the two are never low together.
- R5: After each strobe, the select stays low with the strobe high for exactly `hold` cycles.
- R6: On a 32-bit device one beat runs at byte address `{word,2'b00}`. On a 16-bit device two beats run, at `{word,2'b00}` and then `{word,2'b10}`, using lanes [15:0] only.
- R7: The bus image of a word is the word itself in little-endian mode and its byte-reversed form (byte 0 on lanes [31:24]) in big-endian mode. On a 16-bit device, beat k carries image bits [16k+15:16k], so big-endian sends the high half first.
- R8: Read data is sampled at the end of the last strobe cycle of each beat and reassembled through the inverse of R7. `rsp_rdata` is zero for writes and for errors.
- R9: With acknowledge enabled, the strobe ends in the first cycle in which `bus_ack` is sampled high, whatever `wait` says. With acknowledge disabled, `bus_ack` has no effect.
- R10: With acknowledge enabled, if `bus_ack` stays low for 255 strobe cycles the strobe ends, no hold or further beat follows, and the response carries an error.
- R11: A write to a write-protected region returns an error with no external cycle. Reads from that region run normally.
- R12: `rsp_valid` is high for exactly one cycle, in the cycle after the final hold cycle (or after the final strobe cycle when `hold` is 0). `req_ready` is low from acceptance through that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W-2 | Word address, top 3 bits pick the region |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Error flag of the response |
| rsp_rdata | output | 32 | Read word |
| cfg_wide | input | NUM_CS | Per region: 1 = 32-bit device, 0 = 16-bit |
| cfg_big | input | NUM_CS | Per region: big-endian byte order |
| cfg_ack_en | input | NUM_CS | Per region: acknowledge ends the strobe |
| cfg_wprot | input | NUM_CS | Per region: writes blocked |
| cfg_setup | input | 4*NUM_CS | Per region lead-in count, nibble i for region i |
| cfg_wait | input | 4*NUM_CS | Per region strobe count minus one |
| cfg_hold | input | 4*NUM_CS | Per region tail count |
| bus_cs_n | output | NUM_CS | Active-low region selects |
| bus_oe_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_addr | output | ADDR_W | Byte address of the current beat |
| bus_dq_o | output | 32 | Data driven toward the device |
| bus_dq_oe | output | 1 | Drive enable for `bus_dq_o` |
| bus_dq_i | input | 32 | Data returned by the device |
| bus_ack | input | 1 | Device acknowledge, active high |

## Verification
The bench builds the block with its defaults: six regions, a 24-bit byte address and a 255-cycle acknowledge limit. These give two undecoded select indices (6 and 7) for the error path. The bench gives the six regions six different mixes of width, byte order, acknowledge use and protection, so that every timing path and split path is used. The 255-cycle limit is short enough that full acknowledge timeouts, on a 32-bit read and on the first beat of a 16-bit write, fit in the run next to the normal cycles.

// File: rtl/abg_pkg.sv
`timescale 1ns/1ps
package abg_pkg;

  typedef struct packed {
    logic       wide;
    logic       big;
    logic       ack_en;
    logic       wprot;
    logic [3:0] setup;
    logic [3:0] wt;
    logic [3:0] hold;
  } cs_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RESP
  } phase_e;

  // Byte reversal of a 32-bit word; it is its own inverse.
  function automatic logic [31:0] byte_rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // Word as it appears on the device lanes for the chosen byte order.
  function automatic logic [31:0] lane_image(input logic [31:0] d, input logic big);
    return big ? byte_rev(d) : d;
  endfunction

  // First timed phase of a beat: skip the lead-in when its count is zero.
  function automatic phase_e entry_phase(input logic [3:0] setup);
    return (setup != 4'd0) ? PH_SETUP : PH_STROBE;
  endfunction

endpackage

// File: rtl/abg_cfg_select.sv
`timescale 1ns/1ps
module abg_cfg_select
  import abg_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int SEL_W  = 3
) (
  input  logic [NUM_CS-1:0]   cfg_wide,
  input  logic [NUM_CS-1:0]   cfg_big,
  input  logic [NUM_CS-1:0]   cfg_ack_en,
  input  logic [NUM_CS-1:0]   cfg_wprot,
  input  logic [NUM_CS*4-1:0] cfg_setup,
  input  logic [NUM_CS*4-1:0] cfg_wait,
  input  logic [NUM_CS*4-1:0] cfg_hold,
  input  logic [SEL_W-1:0]    sel,
  output cs_cfg_t             sel_cfg,
  output logic                sel_ok
);

  cs_cfg_t cs_tab [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_tab[i] = '{wide:   cfg_wide[i],
                         big:    cfg_big[i],
                         ack_en: cfg_ack_en[i],
                         wprot:  cfg_wprot[i],
                         setup:  cfg_setup[4*i +: 4],
                         wt:     cfg_wait[4*i +: 4],
                         hold:   cfg_hold[4*i +: 4]};
  end

  always_comb begin
    sel_ok  = (int'(sel) < NUM_CS);
    sel_cfg = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == SEL_W'(i)) sel_cfg = cs_tab[i];
    end
  end

endmodule

// File: rtl/abg_cycle_fsm.sv
`timescale 1ns/1ps
module abg_cycle_fsm
  import abg_pkg::*;
#(
  parameter int TMO   = 255,
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       go_err,
  input  logic       split,
  input  logic       ack_en,
  input  logic [3:0] setup,
  input  logic [3:0] wt,
  input  logic [3:0] hold,
  input  logic       ack,
  output phase_e     phase,
  output logic       beat,
  output logic       strobe_end,
  output logic       tmo_hit,
  output logic       err_q
);

  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO - 1);

  logic [CNT_W-1:0] cnt;
  phase_e           nxt;
  logic             nxt_beat;
  logic             restart;

  function automatic logic last_of(input logic [CNT_W-1:0] c, input logic [3:0] n);
    return (c + CNT_W'(1)) == CNT_W'(n);
  endfunction

  always_comb begin
    tmo_hit    = (phase == PH_STROBE) && ack_en && !ack && (cnt == TMO_LAST);
    strobe_end = (phase == PH_STROBE) &&
                 (ack_en ? (ack || cnt == TMO_LAST) : (cnt == CNT_W'(wt)));
    nxt      = phase;
    nxt_beat = beat;
    case (phase)
      PH_IDLE: if (go) begin
        nxt      = go_err ? PH_RESP : entry_phase(setup);
        nxt_beat = 1'b0;
      end
      PH_SETUP: if (last_of(cnt, setup)) nxt = PH_STROBE;
      PH_STROBE: if (strobe_end) begin
        if (tmo_hit)               nxt = PH_RESP;
        else if (hold != 4'd0)     nxt = PH_HOLD;
        else if (split && !beat) begin
          nxt      = entry_phase(setup);
          nxt_beat = 1'b1;
        end
        else                       nxt = PH_RESP;
      end
      PH_HOLD: if (last_of(cnt, hold)) begin
        if (split && !beat) begin
          nxt      = entry_phase(setup);
          nxt_beat = 1'b1;
        end
        else nxt = PH_RESP;
      end
      PH_RESP: nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
    restart = (nxt != phase) || (nxt_beat != beat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      beat  <= 1'b0;
      cnt   <= '0;
      err_q <= 1'b0;
    end else begin
      phase <= nxt;
      beat  <= nxt_beat;
      cnt   <= restart ? '0 : cnt + CNT_W'(1);
      if (phase == PH_IDLE && go) err_q <= go_err;
      else if (tmo_hit)           err_q <= 1'b1;
    end
  end

  // R10: a strobe never outlives the acknowledge limit
  a_r10_strobe_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE) |-> (cnt <= TMO_LAST));

  // R12: the response phase lasts one cycle
  a_r12_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RESP) |=> (phase == PH_IDLE));

endmodule

// File: rtl/abg_datapath.sv
`timescale 1ns/1ps
module abg_datapath
  import abg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        load_wr,
  input  logic        load_big,
  input  logic [31:0] wdata,
  input  logic        big,
  input  logic        wide,
  input  logic        beat,
  input  logic        cap,
  input  logic [31:0] dq_i,
  output logic [31:0] dq_o,
  output logic [31:0] rdata
);

  logic [31:0] img;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img <= '0;
    end else if (load) begin
      img <= load_wr ? lane_image(wdata, load_big) : '0;
    end else if (cap) begin
      if (wide)      img        <= dq_i;
      else if (beat) img[31:16] <= dq_i[15:0];
      else           img[15:0]  <= dq_i[15:0];
    end
  end

  assign dq_o  = wide ? img : {16'h0000, beat ? img[31:16] : img[15:0]};
  assign rdata = lane_image(img, big);

endmodule

// File: rtl/async_bus_engine.sv
`timescale 1ns/1ps
module async_bus_engine
  import abg_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 24,
  parameter int TMO    = 255
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:2]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [31:0]         rsp_rdata,
  input  logic [NUM_CS-1:0]   cfg_wide,
  input  logic [NUM_CS-1:0]   cfg_big,
  input  logic [NUM_CS-1:0]   cfg_ack_en,
  input  logic [NUM_CS-1:0]   cfg_wprot,
  input  logic [NUM_CS*4-1:0] cfg_setup,
  input  logic [NUM_CS*4-1:0] cfg_wait,
  input  logic [NUM_CS*4-1:0] cfg_hold,
  output logic [NUM_CS-1:0]   bus_cs_n,
  output logic                bus_oe_n,
  output logic                bus_we_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [31:0]         bus_dq_o,
  output logic                bus_dq_oe,
  input  logic [31:0]         bus_dq_i,
  input  logic                bus_ack
);

  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int CNT_W = $clog2(TMO + 1);

  // named internal events
  logic                accept;
  logic                active;
  logic                strobe_end;
  logic                tmo_hit;
  logic                err_q;
  logic                beat;
  logic                sel_ok;
  logic                go_err;
  logic [SEL_W-1:0]    sel;
  cs_cfg_t             sel_cfg;
  cs_cfg_t             act_cfg;
  logic [SEL_W-1:0]    act_cs;
  logic                act_wr;
  logic [ADDR_W-1:2]   act_addr;
  logic                idle;
  phase_e              phase;
  logic [31:0]         dp_rdata;

  assign sel    = req_addr[ADDR_W-1 -: SEL_W];
  assign idle   = (phase == PH_IDLE);
  assign accept = req_valid && idle;
  assign go_err = !sel_ok || (req_write && sel_cfg.wprot);
  assign active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  abg_cfg_select #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_sel (
    .cfg_wide(cfg_wide), .cfg_big(cfg_big), .cfg_ack_en(cfg_ack_en),
    .cfg_wprot(cfg_wprot), .cfg_setup(cfg_setup), .cfg_wait(cfg_wait),
    .cfg_hold(cfg_hold), .sel(sel), .sel_cfg(sel_cfg), .sel_ok(sel_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cfg  <= '0;
      act_cs   <= '0;
      act_wr   <= 1'b0;
      act_addr <= '0;
    end else if (accept) begin
      act_cfg  <= sel_cfg;
      act_cs   <= sel;
      act_wr   <= req_write;
      act_addr <= req_addr;
    end
  end

  abg_cycle_fsm #(.TMO(TMO), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .go(accept), .go_err(go_err),
    .split (idle ? !sel_cfg.wide  : !act_cfg.wide),
    .ack_en(idle ? sel_cfg.ack_en : act_cfg.ack_en),
    .setup (idle ? sel_cfg.setup  : act_cfg.setup),
    .wt    (idle ? sel_cfg.wt     : act_cfg.wt),
    .hold  (idle ? sel_cfg.hold   : act_cfg.hold),
    .ack(bus_ack),
    .phase(phase), .beat(beat), .strobe_end(strobe_end),
    .tmo_hit(tmo_hit), .err_q(err_q)
  );

  abg_datapath u_dp (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_wr(req_write), .load_big(sel_cfg.big), .wdata(req_wdata),
    .big(act_cfg.big), .wide(act_cfg.wide), .beat(beat),
    .cap(strobe_end && !act_wr && !tmo_hit),
    .dq_i(bus_dq_i), .dq_o(bus_dq_o), .rdata(dp_rdata)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csn
    assign bus_cs_n[i] = !(active && act_cs == SEL_W'(i));
  end

  assign bus_oe_n  = !((phase == PH_STROBE) && !act_wr);
  assign bus_we_n  = !((phase == PH_STROBE) &&  act_wr);
  assign bus_dq_oe = active && act_wr;
  assign bus_addr  = {act_addr, beat, 1'b0};
  assign req_ready = idle;
  assign rsp_valid = (phase == PH_RESP);
  assign rsp_err   = err_q;
  assign rsp_rdata = (err_q || act_wr) ? '0 : dp_rdata;

  // R2: at most one select line is active
  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R4: read and write strobes are never active together
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  // R5: a strobe only appears inside an active select
  a_r5_strobe_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> (bus_cs_n != {NUM_CS{1'b1}}));

  // R11: a blocked write yields an error response and no select
  a_r11_protect_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && sel_ok && sel_cfg.wprot)
      |=> (bus_cs_n == {NUM_CS{1'b1}}) && rsp_valid && rsp_err);

  // R11: no write strobe ever reaches a protected region
  a_r11_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> !act_cfg.wprot);

  // R6: a 32-bit device only sees word-aligned addresses
  a_r6_wide_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (active && act_cfg.wide) |-> (bus_addr[1:0] == 2'b00));

  // R12: the block is ready again right after its response
  a_r12_ready_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

endmodule

// File: tb/sim_async_bus_engine.sv
`timescale 1ns/1ps
module sim_async_bus_engine;

  localparam int NUM_CS = 6;
  localparam int ADDR_W = 24;
  localparam int TMO    = 255;

  // bench configuration of the six regions
  localparam logic [5:0]  C_WIDE  = 6'b011001;
  localparam logic [5:0]  C_BIG   = 6'b101100;
  localparam logic [5:0]  C_ACK   = 6'b110000;
  localparam logic [5:0]  C_PROT  = 6'b001000;
  localparam logic [23:0] C_SETUP = 24'h010201;
  localparam logic [23:0] C_WAIT  = 24'hF03102;
  localparam logic [23:0] C_HOLD  = 24'hF10201;

  typedef struct packed {
    logic        wr;
    logic [2:0]  cs;
    logic [11:0] off;
    logic [31:0] wd;
    logic [7:0]  dly;
    logic        eerr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 12'h010, 32'h11223344, 8'd0, 1'b0},
    '{1'b0, 3'd0, 12'h020, 32'h0,        8'd0, 1'b0},
    '{1'b1, 3'd1, 12'h030, 32'hA1B2C3D4, 8'd0, 1'b0},
    '{1'b0, 3'd1, 12'h044, 32'h0,        8'd0, 1'b0},
    '{1'b1, 3'd2, 12'h050, 32'h0BADF00D, 8'd0, 1'b0},
    '{1'b0, 3'd2, 12'h064, 32'h0,        8'd0, 1'b0},
    '{1'b1, 3'd3, 12'h068, 32'hDEADBEEF, 8'd0, 1'b1},
    '{1'b0, 3'd3, 12'h070, 32'h0,        8'd0, 1'b0},
    '{1'b1, 3'd4, 12'h074, 32'h55AA1234, 8'd3, 1'b0},
    '{1'b0, 3'd4, 12'h078, 32'h0,        8'd0, 1'b0},
    '{1'b0, 3'd5, 12'h07C, 32'h0,        8'd5, 1'b0},
    '{1'b1, 3'd5, 12'h080, 32'h89ABCDEF, 8'd1, 1'b0},
    '{1'b0, 3'd6, 12'h084, 32'h0,        8'd0, 1'b1},
    '{1'b1, 3'd7, 12'h088, 32'h01020304, 8'd0, 1'b1}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic                req_write = 1'b0;
  logic [ADDR_W-1:2]   req_addr = '0;
  logic [31:0]         req_wdata = '0;
  logic                rsp_valid;
  logic                rsp_err;
  logic [31:0]         rsp_rdata;
  logic [NUM_CS-1:0]   bus_cs_n;
  logic                bus_oe_n;
  logic                bus_we_n;
  logic [ADDR_W-1:0]   bus_addr;
  logic [31:0]         bus_dq_o;
  logic                bus_dq_oe;
  logic [31:0]         bus_dq_i = '0;
  logic                bus_ack = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // device and monitor state
  bit          mon_on = 1'b0;
  bit          mw_wide = 1'b0;
  logic [23:0] mw_a0 = '0;
  int          ack_dly = 0;
  bit          ack_never = 1'b0;
  bit          ack_force = 1'b0;
  int          s_cnt = 0;
  int          n_strobe, n_quiet, n_pre;
  logic [5:0]  cs_seen;
  logic [31:0] obs_w;
  bit          addr_bad;

  always #2.5 clk = ~clk;

  async_bus_engine #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_wide(C_WIDE), .cfg_big(C_BIG), .cfg_ack_en(C_ACK), .cfg_wprot(C_PROT),
    .cfg_setup(C_SETUP), .cfg_wait(C_WAIT), .cfg_hold(C_HOLD),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe),
    .bus_dq_i(bus_dq_i), .bus_ack(bus_ack)
  );

  function automatic logic [31:0] dev_word(input logic [23:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8], ~a[7:0], a[23:16] ^ 8'h81};
  endfunction

  function automatic logic [31:0] swap4(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic int nib(input logic [23:0] v, input int i);
    return int'(v[4*i +: 4]);
  endfunction

  // device, acknowledge and bus monitor, all away from the active edge
  always @(negedge clk) begin
    logic strobe;
    strobe = !bus_oe_n || !bus_we_n;
    bus_dq_i <= !bus_oe_n ? dev_word(bus_addr) : 32'h0;
    if (strobe) begin
      bus_ack <= ack_force || (!ack_never && s_cnt >= ack_dly);
      s_cnt   <= s_cnt + 1;
    end else begin
      bus_ack <= ack_force;
      s_cnt   <= 0;
    end
    if (mon_on && bus_cs_n != 6'h3F) begin
      cs_seen |= ~bus_cs_n;
      if (bus_addr[23:2] != mw_a0[23:2] || bus_addr[0] || (mw_wide && bus_addr[1]))
        addr_bad = 1'b1;
      if (strobe) begin
        n_strobe++;
        if (!bus_we_n) begin
          if (mw_wide)          obs_w = bus_dq_o;
          else if (bus_addr[1]) obs_w[31:16] = bus_dq_o[15:0];
          else                  obs_w[15:0]  = bus_dq_o[15:0];
        end
      end else begin
        n_quiet++;
        if (n_strobe == 0) n_pre++;
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [2:0] cs, input logic [11:0] off,
                         input logic [31:0] wd, input int dly, input bit never,
                         input bit force_ack, input bit eerr);
    bit   dec_err, wide, big, acken;
    int   s, w, h, beats, len, exp_lat, exp_str, exp_quiet, lat;
    logic [23:0] a0;
    logic [31:0] img, exp_rd;
    string rq_t;
    dec_err = (cs > 3'd5) || (wr && C_PROT[cs]);
    wide  = (cs <= 3'd5) ? C_WIDE[cs] : 1'b1;
    big   = (cs <= 3'd5) ? C_BIG[cs]  : 1'b0;
    acken = (cs <= 3'd5) ? C_ACK[cs]  : 1'b0;
    s = (cs <= 3'd5) ? nib(C_SETUP, int'(cs)) : 0;
    w = (cs <= 3'd5) ? nib(C_WAIT,  int'(cs)) : 0;
    h = (cs <= 3'd5) ? nib(C_HOLD,  int'(cs)) : 0;
    a0 = {cs, 9'h000, off[11:2], 2'b00};
    beats = wide ? 1 : 2;
    len = acken ? (never ? TMO : dly + 1) : w + 1;
    rq_t = acken ? "R9" : "R4";
    if (dec_err) begin
      exp_lat = 1; exp_str = 0; exp_quiet = 0;
    end else if (acken && never) begin
      exp_lat = s + TMO + 1; exp_str = TMO; exp_quiet = s; rq_t = "R10";
    end else begin
      exp_lat = beats * (s + len + h) + 1; exp_str = beats * len; exp_quiet = beats * (s + h);
    end
    img = big ? swap4(wd) : wd;
    exp_rd = wide ? dev_word(a0) : {dev_word(a0 | 24'h2)[15:0], dev_word(a0)[15:0]};
    exp_rd = big ? swap4(exp_rd) : exp_rd;
    if (wr || dec_err || (acken && never)) exp_rd = 32'h0;

    @(negedge clk);
    n_strobe = 0; n_quiet = 0; n_pre = 0; cs_seen = '0; obs_w = '0; addr_bad = 1'b0;
    mw_wide = wide; mw_a0 = a0;
    ack_dly = dly; ack_never = never; ack_force = force_ack; mon_on = 1'b1;
    req_valid = 1'b1; req_write = wr; req_addr = a0[23:2]; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    lat = 1;
    chk("R12", "ready low while busy", {31'h0, req_ready}, 32'h0);
    while (!rsp_valid && lat < 2000) begin
      @(negedge clk);
      #1;
      lat++;
    end
    mon_on = 1'b0;
    chk("R12", "response latency", lat, exp_lat);
    chk(dec_err ? (cs > 3'd5 ? "R2" : "R11") : "R10", "error flag",
        {31'h0, rsp_err}, {31'h0, dec_err || (acken && never)});
    chk(wr ? "R8" : "R7", "response data", rsp_rdata, exp_rd);
    chk(rq_t, "strobe cycles", n_strobe, exp_str);
    chk("R3", "lead-in cycles", n_pre, dec_err ? 0 : s);
    chk("R5", "select-only cycles", n_quiet, exp_quiet);
    chk("R2", "selects seen", {26'h0, cs_seen}, dec_err ? 32'h0 : (32'h1 << cs));
    chk("R6", "beat addresses", {31'h0, addr_bad}, 32'h0);
    if (wr && !dec_err && !(acken && never))
      chk("R7", "bus write image", obs_w, img);
    if (eerr != (dec_err || (acken && never)))
      chk("R2", "table error column", {31'h0, eerr}, {31'h0, dec_err});
    @(negedge clk);
    #1;
    chk("R12", "ready after response", {30'h0, req_ready, rsp_valid}, 32'h2);
    ack_force = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: idle outputs during and right after reset
    chk("R1", "selects in reset", {26'h0, bus_cs_n}, 32'h3F);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "selects idle", {26'h0, bus_cs_n}, 32'h3F);
    chk("R1", "strobes/enable idle", {29'h0, bus_oe_n, bus_we_n, bus_dq_oe}, 32'h6);
    chk("R1", "ready/resp idle", {30'h0, req_ready, rsp_valid}, 32'h2);

    for (int i = 0; i < NV; i++)
      run_txn(VEC[i].wr, VEC[i].cs, VEC[i].off, VEC[i].wd, int'(VEC[i].dly),
              1'b0, 1'b0, VEC[i].eerr);

    // R9: acknowledge held high has no effect on a region that ignores it
    run_txn(1'b0, 3'd0, 12'h0A0, 32'h0, 0, 1'b0, 1'b1, 1'b0);
    // R10: acknowledge never arrives on a 32-bit read
    run_txn(1'b0, 3'd4, 12'h0B0, 32'h0, 0, 1'b1, 1'b0, 1'b1);
    // R10: timeout on the first beat of a 16-bit write stops the second beat
    run_txn(1'b1, 3'd5, 12'h0C0, 32'hCAFEF00D, 0, 1'b1, 1'b0, 1'b1);
    // R11: a read from the protected region after a blocked write still runs
    run_txn(1'b0, 3'd3, 12'h0D0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    // R6/R7: little-endian 16-bit write at a fresh offset
    run_txn(1'b1, 3'd1, 12'h0E4, 32'h76543210, 0, 1'b0, 1'b0, 1'b0);

    finish_up();
  end

endmodule